// File: doc/BRIEF.md
# DDR SDRAM Command Sequencer

This block sits on the controller side of a four-bank double-data-rate SDRAM. It takes single read or write requests (bank, row, column, optional self-closing) over a valid/ready channel and turns them into correctly spaced device commands. These commands are activate, read, write, single-bank close, all-bank close, auto refresh and mode-register load. They are driven on the command strobes, the bank select and a 12-bit shared row/column address, with bit 10 qualifying closes and self-closing accesses. The block records which row each bank holds open. A request to the open row is issued directly. A request to another row first closes the bank and then opens the new row.

After reset the block waits a power-up delay and then runs a fixed bring-up sequence: all-bank close, extended mode load, mode load with the burst length and CAS latency, and two refreshes. It then serves requests. A refresh timer raises a need for refresh at a fixed interval. That need wins over requests: all banks are closed if any is open, and then one refresh is issued. A self-refresh input parks the device with the clock enable low and resumes after an exit delay. Two outputs tell the data path, for each clock cycle, whether a read beat is due at the rising or the falling edge. The half-cycle CAS latency setting moves these beats by half a clock.

Back-pressure rule: a request is taken on a clock edge where `req_valid` and `req_ready` are both high. While `req_valid` is high and `req_ready` is low, the requester keeps every request field unchanged. `req_ready` is high only in the cycle in which the read or write for that request is decided. The command appears on the pins one cycle later.

Top module: `ddr_cmd_seq`

## Requirements
- R1: While reset is asserted the pins show NOP with cke high and no read beat, and `req_ready` is low. After release, NOP is held until T_INIT+1 cycles have passed. Then the bring-up commands follow, spaced by T_RP, T_MRD, T_MRD, T_RFC and T_RFC: close-all (addr[10]=1), extended mode load (ba=1, addr=0), mode load (ba=0, addr[2:0]=log2 of burst length, addr[3]=interleave flag, addr[6:4]=010 for CL 2.0 or 110 for CL 2.5, other bits 0), refresh, and refresh.
- R2: Commands are encoded on {ras_n,cas_n,we_n}: NOP 111, activate 011, read 101, write 100, close 010, refresh 001, mode load 000. Bank select and address are 0 whenever the command is NOP or refresh.
- R3: A request to a bank with no open row issues activate with the row on addr and the bank on ba.
- R4: A request to the open row of its bank issues read or write, with the column on addr[9:0], the self-close flag on addr[10] and addr[11]=0. `req_ready` is high in the decision cycle, and the next command follows no sooner than BURST_LEN/2 cycles later.
- R5: A request to a bank holding a different row first issues a close of that bank (addr[10]=0) and then an activate of the new row.
- R6: An access with the self-close flag leaves its bank closed, and the next command waits BURST_LEN/2+T_RP cycles.
- R7: After T_REFI cycles of normal operation a refresh becomes due. It takes priority over requests. If any bank is open, a close-all is issued first, and then refresh with T_RFC recovery. The interval restarts on expiry.
- R8: With `self_req` high, and no refresh due, open banks are closed and then refresh is issued with cke low. cke stays low with NOPs until `self_req` falls. cke then rises and the next command waits T_XSR cycles. The refresh timer restarts from zero.
- R9: For a read on the pins in cycle k, beats fall on half-cycles 2k+4..2k+3+BURST_LEN at CL 2.0 (`cfg_cl25`=0) or 2k+5..2k+4+BURST_LEN at CL 2.5. `rd_rise` is high in cycle c when half 2c is a beat, and `rd_fall` when half 2c+1 is.
- R10: `req_ready` is never high without `req_valid`. One request is consumed per handshake.
- R11: No command is issued before the recovery of the previous one has elapsed: activate T_RCD, close T_RP, refresh T_RFC, mode load T_MRD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; everything is sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cl25 | input | 1 | CAS latency select: 0 for 2.0, 1 for 2.5 (held static) |
| self_req | input | 1 | Request to enter and stay in self refresh |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_autopre | input | 1 | Close the bank after this access |
| req_bank | input | 2 | Target bank |
| req_row | input | 12 | Target row |
| req_col | input | 10 | Target column |
| cke | output | 1 | Clock enable to the device |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 2 | Bank select |
| addr | output | 12 | Row, column or mode address; bit 10 qualifies closes |
| rd_rise | output | 1 | A read beat is due at this cycle's rising edge |
| rd_fall | output | 1 | A read beat is due at this cycle's falling edge |

## Verification
`req_ready` is a same-cycle result of the registered state and the inputs, so it is compared half a clock after the inputs change. Commands, bank, address and cke come from one register stage and are compared in the cycle after the decision edge. Read beats are due two or more cycles after the read appears on the pins, depending on the half-cycle latency. They are checked per cycle against a half-cycle ledger in which the bench records each read. A behavioural model holding open rows, the refresh interval and recovery counts predicts every cycle, so each spacing and priority is checked in the exact cycle it should take effect.

// File: rtl/ddr_seq_pkg.sv
package ddr_seq_pkg;
  // {ras_n, cas_n, we_n}
  typedef enum logic [2:0] {
    C_MRS = 3'b000,
    C_REF = 3'b001,
    C_PRE = 3'b010,
    C_ACT = 3'b011,
    C_WR  = 3'b100,
    C_RD  = 3'b101,
    C_NOP = 3'b111
  } ddr_cmd_e;

  typedef enum logic [1:0] {
    PH_INIT,
    PH_RUN,
    PH_SELF
  } seq_phase_e;
endpackage

// File: rtl/ddr_bank_table.sv
module ddr_bank_table #(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 12,
  localparam int BA_W     = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 upd_act,
  input  logic                 upd_close,
  input  logic                 upd_close_all,
  input  logic [BA_W-1:0]      sel_bank,
  input  logic [ROW_W-1:0]     sel_row,
  output logic                 q_open,
  output logic                 q_hit,
  output logic                 any_open
);
  logic [NUM_BANKS-1:0]            open_v;
  logic [NUM_BANKS-1:0][ROW_W-1:0] rows;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic             open_q;
    logic [ROW_W-1:0] row_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        open_q <= 1'b0;
        row_q  <= '0;
      end else if (upd_close_all) begin
        open_q <= 1'b0;
      end else if (sel_bank == BA_W'(b)) begin
        if (upd_act) begin
          open_q <= 1'b1;
          row_q  <= sel_row;
        end else if (upd_close) begin
          open_q <= 1'b0;
        end
      end
    end
    assign open_v[b] = open_q;
    assign rows[b]   = row_q;
  end

  assign q_open   = open_v[sel_bank];
  assign q_hit    = q_open && (rows[sel_bank] == sel_row);
  assign any_open = |open_v;
endmodule

// File: rtl/ddr_refresh_timer.sv
module ddr_refresh_timer #(
  parameter int T_REFI = 1560,
  localparam int CW    = $clog2(T_REFI)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic ack,
  output logic due
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      due <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      due <= 1'b0;
    end else begin
      if (ack) due <= 1'b0;
      if (cnt == CW'(T_REFI - 1)) begin
        cnt <= '0;
        due <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ddr_read_window.sv
module ddr_read_window #(
  parameter int BURST_LEN = 4,
  localparam int BEATS    = BURST_LEN / 2,
  localparam int D        = BEATS + 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_now,
  input  logic cl25,
  output logic rd_rise,
  output logic rd_fall
);
  logic [D-1:0] rise_sr, fall_sr, rise_mask, fall_mask;

  // index j of the shift lines is the cycle j after the current one
  always_comb begin
    for (int j = 0; j < D; j++) begin
      rise_mask[j] = cl25 ? (j >= 2 && j <= BEATS + 1) : (j >= 1 && j <= BEATS);
      fall_mask[j] = (j >= 1 && j <= BEATS);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_sr <= '0;
      fall_sr <= '0;
    end else begin
      rise_sr <= (rise_sr >> 1) | (rd_now ? rise_mask : '0);
      fall_sr <= (fall_sr >> 1) | (rd_now ? fall_mask : '0);
    end
  end

  assign rd_rise = rise_sr[0];
  assign rd_fall = fall_sr[0];
endmodule

// File: rtl/ddr_cmd_seq.sv
module ddr_cmd_seq
  import ddr_seq_pkg::*;
#(
  parameter int NUM_BANKS        = 4,
  parameter int ROW_W            = 12,
  parameter int COL_W            = 10,
  parameter int BURST_LEN        = 4,
  parameter int BURST_INTERLEAVE = 0,
  parameter int T_INIT           = 200,
  parameter int T_RP             = 3,
  parameter int T_RCD            = 3,
  parameter int T_RFC            = 10,
  parameter int T_MRD            = 2,
  parameter int T_XSR            = 20,
  parameter int T_REFI           = 1560,
  localparam int BA_W            = $clog2(NUM_BANKS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_cl25,
  input  logic             self_req,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic             req_autopre,
  input  logic [BA_W-1:0]  req_bank,
  input  logic [ROW_W-1:0] req_row,
  input  logic [COL_W-1:0] req_col,
  output logic             cke,
  output logic             ras_n,
  output logic             cas_n,
  output logic             we_n,
  output logic [BA_W-1:0]  ba,
  output logic [ROW_W-1:0] addr,
  output logic             rd_rise,
  output logic             rd_fall
);
  localparam int BEATS = BURST_LEN / 2;

  function automatic int max_wait();
    int m;
    m = T_INIT;
    if (T_RFC > m) m = T_RFC;
    if (T_XSR > m) m = T_XSR;
    if (T_RCD > m) m = T_RCD;
    if (T_MRD > m) m = T_MRD;
    if (BEATS + T_RP > m) m = BEATS + T_RP;
    return m;
  endfunction

  localparam int MAXW  = max_wait();
  localparam int GAP_W = $clog2(MAXW + 1);
  localparam logic [2:0] BL_CODE = 3'($clog2(BURST_LEN));

  seq_phase_e       phase_q, n_phase;
  logic [GAP_W-1:0] gap_q, n_wait;
  logic [2:0]       step_q, n_step;
  ddr_cmd_e         cmd_q, n_cmd;
  logic [BA_W-1:0]  ba_q, n_ba;
  logic [ROW_W-1:0] addr_q, n_addr, mode_word;
  logic             cke_q, n_cke;
  logic             issue, ack, do_act, do_close, do_close_all;
  logic             q_open, q_hit, any_open, ref_due, slot;

  assign slot = (gap_q == '0);

  always_comb begin
    mode_word      = '0;
    mode_word[2:0] = BL_CODE;
    mode_word[3]   = (BURST_INTERLEAVE != 0);
    mode_word[6:4] = cfg_cl25 ? 3'b110 : 3'b010;
  end

  ddr_bank_table #(.NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W)) u_banks (
    .clk(clk), .rst_n(rst_n),
    .upd_act(do_act), .upd_close(do_close), .upd_close_all(do_close_all),
    .sel_bank(req_bank), .sel_row(req_row),
    .q_open(q_open), .q_hit(q_hit), .any_open(any_open)
  );

  ddr_refresh_timer #(.T_REFI(T_REFI)) u_refi (
    .clk(clk), .rst_n(rst_n), .run(phase_q == PH_RUN), .ack(ack), .due(ref_due)
  );

  ddr_read_window #(.BURST_LEN(BURST_LEN)) u_rdwin (
    .clk(clk), .rst_n(rst_n), .rd_now(cmd_q == C_RD), .cl25(cfg_cl25),
    .rd_rise(rd_rise), .rd_fall(rd_fall)
  );

  always_comb begin
    n_cmd        = C_NOP;
    n_ba         = '0;
    n_addr       = '0;
    n_cke        = cke_q;
    n_phase      = phase_q;
    n_step       = step_q;
    n_wait       = '0;
    issue        = 1'b0;
    ack          = 1'b0;
    req_ready    = 1'b0;
    do_act       = 1'b0;
    do_close     = 1'b0;
    do_close_all = 1'b0;
    unique case (phase_q)
      PH_INIT: if (slot) begin
        issue  = 1'b1;
        n_step = step_q + 3'd1;
        unique case (step_q)
          3'd0: begin
            n_cmd = C_PRE; n_addr[10] = 1'b1; n_wait = GAP_W'(T_RP); do_close_all = 1'b1;
          end
          3'd1: begin
            n_cmd = C_MRS; n_ba = BA_W'(1); n_wait = GAP_W'(T_MRD);
          end
          3'd2: begin
            n_cmd = C_MRS; n_addr = mode_word; n_wait = GAP_W'(T_MRD);
          end
          default: begin
            n_cmd = C_REF; n_wait = GAP_W'(T_RFC);
            if (step_q == 3'd4) n_phase = PH_RUN;
          end
        endcase
      end
      PH_RUN: if (slot) begin
        if (ref_due || self_req) begin
          issue = 1'b1;
          if (any_open) begin
            n_cmd = C_PRE; n_addr[10] = 1'b1; n_wait = GAP_W'(T_RP); do_close_all = 1'b1;
          end else if (ref_due) begin
            n_cmd = C_REF; n_wait = GAP_W'(T_RFC); ack = 1'b1;
          end else begin
            n_cmd = C_REF; n_wait = GAP_W'(1); n_cke = 1'b0; n_phase = PH_SELF;
          end
        end else if (req_valid) begin
          issue = 1'b1;
          n_ba  = req_bank;
          if (q_hit) begin
            n_cmd             = req_write ? C_WR : C_RD;
            n_addr[COL_W-1:0] = req_col;
            n_addr[10]        = req_autopre;
            n_wait            = GAP_W'(BEATS) + (req_autopre ? GAP_W'(T_RP) : '0);
            do_close          = req_autopre;
            req_ready         = 1'b1;
          end else if (q_open) begin
            n_cmd = C_PRE; n_wait = GAP_W'(T_RP); do_close = 1'b1;
          end else begin
            n_cmd = C_ACT; n_addr = req_row; n_wait = GAP_W'(T_RCD); do_act = 1'b1;
          end
        end
      end
      default: if (!self_req) begin
        issue   = 1'b1;
        n_cke   = 1'b1;
        n_phase = PH_RUN;
        n_wait  = GAP_W'(T_XSR);
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_INIT;
      gap_q   <= GAP_W'(T_INIT);
      step_q  <= '0;
      cmd_q   <= C_NOP;
      ba_q    <= '0;
      addr_q  <= '0;
      cke_q   <= 1'b1;
    end else begin
      phase_q <= n_phase;
      step_q  <= n_step;
      cmd_q   <= n_cmd;
      ba_q    <= n_ba;
      addr_q  <= n_addr;
      cke_q   <= n_cke;
      if (issue)           gap_q <= n_wait - 1'b1;
      else if (gap_q != 0) gap_q <= gap_q - 1'b1;
    end
  end

  assign {ras_n, cas_n, we_n} = cmd_q;
  assign ba   = ba_q;
  assign addr = addr_q;
  assign cke  = cke_q;
endmodule

// File: rtl/ddr_cmd_seq_chk.sv
module ddr_cmd_seq_chk #(
  parameter int BURST_LEN = 4,
  parameter int T_RP      = 3,
  parameter int T_RCD     = 3,
  parameter int T_RFC     = 10,
  parameter int T_MRD     = 2,
  parameter int BA_W      = 2,
  parameter int ROW_W     = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             cke,
  input logic             ras_n,
  input logic             cas_n,
  input logic             we_n,
  input logic [BA_W-1:0]  ba,
  input logic [ROW_W-1:0] addr
);
  localparam logic [2:0] K_NOP = 3'b111, K_ACT = 3'b011, K_RD = 3'b101,
                         K_WR = 3'b100, K_PRE = 3'b010, K_REF = 3'b001, K_MRS = 3'b000;
  localparam int NB = 1 << BA_W;

  logic [2:0]    cmd;
  logic [NB-1:0] open_b;
  logic          seen;
  int            since, need;

  assign cmd = {ras_n, cas_n, we_n};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_b <= '0;
      seen   <= 1'b0;
      since  <= 0;
      need   <= 0;
    end else begin
      if (cmd != K_NOP) begin
        seen  <= 1'b1;
        since <= 1;
        unique case (cmd)
          K_ACT:       need <= T_RCD;
          K_PRE:       need <= T_RP;
          K_REF:       need <= T_RFC;
          K_MRS:       need <= T_MRD;
          default:     need <= BURST_LEN / 2 + (addr[10] ? T_RP : 0);
        endcase
      end else if (since < 1000000) begin
        since <= since + 1;
      end
      if (cmd == K_ACT) open_b[ba] <= 1'b1;
      if (cmd == K_PRE && addr[10]) open_b <= '0;
      else if (cmd == K_PRE) open_b[ba] <= 1'b0;
      if ((cmd == K_RD || cmd == K_WR) && addr[10]) open_b[ba] <= 1'b0;
    end
  end

  // R10
  ready_has_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> req_valid);
  // R3
  act_on_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == K_ACT) |-> !open_b[ba]);
  // R4
  access_on_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == K_RD || cmd == K_WR) |-> open_b[ba]);
  // R7
  refresh_all_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == K_REF) |-> (open_b == '0));
  // R8
  self_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke && $past(!cke)) |-> (cmd == K_NOP));
  // R11
  recovery_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd != K_NOP && seen) |-> (since >= need));
endmodule

bind ddr_cmd_seq ddr_cmd_seq_chk #(
  .BURST_LEN(BURST_LEN), .T_RP(T_RP), .T_RCD(T_RCD), .T_RFC(T_RFC),
  .T_MRD(T_MRD), .BA_W(BA_W), .ROW_W(ROW_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .cke(cke), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr)
);

// File: tb/ddr_cmd_seq_test.sv
module ddr_cmd_seq_test;
  localparam int BL = 4, T_INIT = 8, T_RP = 3, T_RCD = 3, T_RFC = 7,
                 T_MRD = 2, T_XSR = 10, T_REFI = 60;
  localparam int NOP = 7, ACT = 3, RD = 5, WR = 4, PRE = 2, REF = 1, MRS = 0;

  logic clk = 0, rst_n = 0, cfg_cl25 = 0, self_req = 0;
  logic req_valid = 0, req_write = 0, req_autopre = 0;
  logic [1:0] req_bank = 0;
  logic [11:0] req_row = 0;
  logic [9:0] req_col = 0;
  logic req_ready, cke, ras_n, cas_n, we_n, rd_rise, rd_fall;
  logic [1:0] ba;
  logic [11:0] addr;

  always #10 clk = ~clk;

  ddr_cmd_seq #(.BURST_LEN(BL), .T_INIT(T_INIT), .T_RP(T_RP), .T_RCD(T_RCD),
    .T_RFC(T_RFC), .T_MRD(T_MRD), .T_XSR(T_XSR), .T_REFI(T_REFI)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_cl25(cfg_cl25), .self_req(self_req),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_autopre(req_autopre), .req_bank(req_bank), .req_row(req_row),
    .req_col(req_col), .cke(cke), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ba(ba), .addr(addr), .rd_rise(rd_rise), .rd_fall(rd_fall));

  int checks = 0, errors = 0;
  bit done = 0;

  // request queues
  int q_bank[$], q_row[$], q_col[$], q_wr[$], q_ap[$];

  // reference model state
  int m_ph, m_gap, m_step, m_cke, m_rcnt, m_pend, cyc;
  int m_open[4], m_row[4];
  int e_cmd, e_ba, e_addr, e_cke;
  bit hb[256];
  int d_cmd, d_ba, d_addr, d_w, d_ready, d_ack, d_ph, d_cke, d_step;
  int d_act, d_pre1, d_preall;
  int n_act, n_pre1, n_ref, n_ap, n_self, n_fall_only;

  function automatic string tag_of(int c, int a10);
    case (c)
      ACT: return "R3";
      RD, WR: return a10 ? "R6" : "R4";
      PRE: return a10 ? "R7" : "R5";
      REF: return "R7";
      MRS: return "R1";
      default: return "R11";
    endcase
  endfunction

  task automatic fail(string r, string what, int act_v, int exp_v);
    errors++;
    $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", r, what, act_v, exp_v, cyc);
  endtask

  task automatic push(int b, int r, int c, int w, int ap);
    q_bank.push_back(b); q_row.push_back(r); q_col.push_back(c);
    q_wr.push_back(w); q_ap.push_back(ap);
  endtask

  task automatic decide();
    int any, b;
    d_cmd = NOP; d_ba = 0; d_addr = 0; d_w = 0; d_ready = 0; d_ack = 0;
    d_ph = m_ph; d_cke = m_cke; d_step = m_step; d_act = 0; d_pre1 = 0; d_preall = 0;
    any = m_open[0] | m_open[1] | m_open[2] | m_open[3];
    if (m_ph == 0) begin
      if (m_gap == 0) begin
        d_step = m_step + 1;
        case (m_step)
          0: begin d_cmd = PRE; d_addr = 1024; d_w = T_RP; d_preall = 1; end
          1: begin d_cmd = MRS; d_ba = 1; d_w = T_MRD; end
          2: begin d_cmd = MRS; d_addr = (cfg_cl25 ? 96 : 32) + 2; d_w = T_MRD; end
          default: begin d_cmd = REF; d_w = T_RFC; if (m_step == 4) d_ph = 1; end
        endcase
      end
    end else if (m_ph == 1) begin
      if (m_gap == 0) begin
        if (m_pend || self_req) begin
          if (any) begin d_cmd = PRE; d_addr = 1024; d_w = T_RP; d_preall = 1; end
          else if (m_pend) begin d_cmd = REF; d_w = T_RFC; d_ack = 1; end
          else begin d_cmd = REF; d_w = 1; d_cke = 0; d_ph = 2; end
        end else if (req_valid) begin
          b = req_bank; d_ba = b;
          if (m_open[b] && m_row[b] == req_row) begin
            d_cmd = req_write ? WR : RD; d_addr = req_col + (req_autopre ? 1024 : 0);
            d_w = BL / 2 + (req_autopre ? T_RP : 0); d_ready = 1; d_pre1 = req_autopre;
          end else if (m_open[b]) begin
            d_cmd = PRE; d_w = T_RP; d_pre1 = 1;
          end else begin
            d_cmd = ACT; d_addr = req_row; d_w = T_RCD; d_act = 1;
          end
        end
      end
    end else if (!self_req) begin
      d_cke = 1; d_ph = 1; d_w = T_XSR;
    end
  endtask

  task automatic apply();
    if (m_ph == 1) begin
      if (d_ack) m_pend = 0;
      if (m_rcnt == T_REFI - 1) begin m_rcnt = 0; m_pend = 1; end
      else m_rcnt++;
    end else begin
      m_rcnt = 0; m_pend = 0;
    end
    if (d_w > 0) m_gap = d_w - 1;
    else if (m_gap > 0) m_gap--;
    if (d_preall) for (int i = 0; i < 4; i++) m_open[i] = 0;
    if (d_act) begin m_open[d_ba] = 1; m_row[d_ba] = int'(req_row); end
    if (d_pre1) m_open[d_ba] = 0;
    m_ph = d_ph; m_step = d_step; m_cke = d_cke;
    e_cmd = d_cmd; e_ba = d_ba; e_addr = d_addr; e_cke = d_cke;
    cyc++;
    if (d_cmd == RD)
      for (int i = 0; i < BL; i++) hb[(2 * cyc + (cfg_cl25 ? 5 : 4) + i) % 256] = 1;
  endtask

  task automatic step();
    int pins;
    #5;
    decide();
    checks++;
    if (req_ready !== d_ready[0]) fail("R10", "req_ready", req_ready, d_ready);
    @(posedge clk);
    #1;
    apply();
    #4;
    pins = {cke, ras_n, cas_n, we_n, ba, addr};
    checks++;
    if (pins !== {e_cke[0], e_cmd[2:0], e_ba[1:0], e_addr[11:0]}) begin
      if (cke !== e_cke[0]) fail("R8", "cke", cke, e_cke);
      else fail(tag_of(e_cmd, e_addr[10]), "pins {cmd,ba,addr}",
                {ras_n, cas_n, we_n, ba, addr}, {e_cmd[2:0], e_ba[1:0], e_addr[11:0]});
    end
    checks++;
    if (rd_rise !== hb[(2 * cyc) % 256] || rd_fall !== hb[(2 * cyc + 1) % 256])
      fail("R9", "read beats {rise,fall}", {rd_rise, rd_fall},
           {hb[(2 * cyc) % 256], hb[(2 * cyc + 1) % 256]});
    hb[(2 * cyc) % 256] = 0;
    hb[(2 * cyc + 1) % 256] = 0;
    if (e_cmd == ACT) n_act++;
    if (e_cmd == PRE && !e_addr[10]) n_pre1++;
    if (e_cmd == REF && m_ph == 1) n_ref++;
    if ((e_cmd == RD || e_cmd == WR) && e_addr[10]) n_ap++;
    if (!cke) n_self++;
    if (rd_fall && !rd_rise) n_fall_only++;
    @(negedge clk);
    if (req_valid && d_ready) req_valid = 0;
    if (!req_valid && q_bank.size() > 0) begin
      req_bank = 2'(q_bank.pop_front()); req_row = 12'(q_row.pop_front());
      req_col = 10'(q_col.pop_front()); req_write = q_wr.pop_front() != 0;
      req_autopre = q_ap.pop_front() != 0;
      req_valid = 1;
    end
  endtask

  task automatic run_cycles(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic do_reset(bit cl);
    rst_n = 0; req_valid = 0; self_req = 0; cfg_cl25 = cl;
    q_bank.delete(); q_row.delete(); q_col.delete(); q_wr.delete(); q_ap.delete();
    repeat (3) @(negedge clk);
    checks++;
    if ({cke, ras_n, cas_n, we_n, rd_rise, rd_fall, req_ready} !== 7'b1111000)
      fail("R1", "reset state {cke,cmd,rise,fall,ready}",
           {cke, ras_n, cas_n, we_n, rd_rise, rd_fall, req_ready}, 7'b1111000);
    m_ph = 0; m_gap = T_INIT; m_step = 0; m_cke = 1; m_rcnt = 0; m_pend = 0; cyc = 0;
    for (int i = 0; i < 4; i++) begin m_open[i] = 0; m_row[i] = 0; end
    for (int i = 0; i < 256; i++) hb[i] = 0;
    e_cmd = NOP; e_ba = 0; e_addr = 0; e_cke = 1;
    rst_n = 1;
  endtask

  task automatic load_set();
    push(0, 5, 3, 0, 0);    push(0, 5, 8, 0, 0);     push(0, 9, 16, 1, 0);
    push(1, 7, 2, 1, 1);    push(1, 7, 4, 0, 0);     push(3, 4095, 1023, 0, 1);
    push(2, 0, 0, 0, 0);    push(2, 0, 1, 0, 0);     push(0, 9, 20, 0, 1);
    push(1, 100, 5, 1, 0);  push(1, 100, 6, 0, 0);   push(2, 33, 9, 0, 0);
  endtask

  task automatic expect_seen(string r, string what, int cnt);
    checks++;
    if (cnt == 0) fail(r, what, cnt, 1);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    n_act = 0; n_pre1 = 0; n_ref = 0; n_ap = 0; n_self = 0; n_fall_only = 0;
    @(negedge clk);
    // CL 2.0 pass: bring-up (R1, R2), hits, misses, self-close, refresh, self refresh
    do_reset(0);
    load_set();
    run_cycles(260);
    self_req = 1;
    push(3, 12, 7, 0, 0);
    run_cycles(40);
    self_req = 0;
    run_cycles(100);
    expect_seen("R3", "activates issued", n_act);
    expect_seen("R5", "single-bank closes issued", n_pre1);
    expect_seen("R6", "self-closing accesses issued", n_ap);
    expect_seen("R7", "refreshes in normal operation", n_ref);
    expect_seen("R8", "cycles with cke low", n_self);
    // CL 2.5 pass: half-cycle read placement (R9)
    do_reset(1);
    load_set();
    push(0, 5, 12, 0, 0);
    run_cycles(300);
    expect_seen("R9", "cycles with a falling-edge-only beat", n_fall_only);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R11 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end
endmodule